// File: doc/BRIEF.md
# Two-Level Virtual Frequency Splitter

This block runs a task at a clock rate that lies between two of the available discrete speed levels. It does this by running part of the task's cycles at the nearest level above the target and the rest at the nearest level below it. On an accepted start it takes a cycle budget and a target rate, and finds the two bounding levels in an equally spaced level table. It then works out how many cycles must run at the upper level so that the whole task takes no longer than it would at the target rate. The switch time can be included in that calculation when requested.

During the run the block counts one executed cycle per `tick`. Its registered `speed_sel` output names the upper level until the high-phase count is reached, and the lower level for the remaining cycles. A one-cycle `done` pulse closes the run. The block does not generate clocks and does not drive the supply. It only selects the level that the surrounding logic should apply.

Top module: `vfreq_split`

## Requirements
- R1: Level i (0 to N_LVL-1) has frequency F_BASE + i*F_STEP, which gives 5 to 80 in steps of 5 by default. `speed_sel` reports the level as its index i.
- R2: The upper level is the lowest level whose frequency is at least the target. The lower level is the highest level whose frequency is at most the target.
- R3: Without overhead, the high-phase count NH is ceil(N*fH*(fv-fL) / (fv*(fH-fL))), where fH and fL are the bounding frequencies and fv is the target. The result is rounded up, so the achieved rate is never below the target.
- R4: When `ovh_en` is 1, the numerator also gains ovh*fH*fL. Here ovh is the switch time expressed in cycles of the target rate. NH is limited to N. When `ovh_en` is 0, `ovh_cyc` has no effect.
- R5: A target equal to a table level gives NH = N, and `speed_sel` stays at that level for the whole run.
- R6: A target above the top level runs entirely at the top level, and a target below the bottom level runs entirely at the bottom level. In both cases `clamped` is 1. `clamped` is updated at each accepted start and held until the next one.
- R7: The first NH ticks of a run see `speed_sel` at the upper level, and the remaining N-NH ticks see the lower level. Ticks are counted from the (NUM_W+3)-th rising edge after the accepted start at the latest, where NUM_W = CNT_W+2*F_W+1. Ticks before that have no effect.
- R8: `done` is high for exactly one cycle, in the cycle after the edge that samples the N-th counted tick. `busy` falls at that same edge.
- R9: `busy` rises in the cycle after an accepted start. A `start` while `busy` is 1 is ignored and leaves the current run and `clamped` unchanged.
- R10: After reset, `busy`, `done` and `clamped` are 0 and `speed_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the values on the parameter inputs |
| cyc_total | input | CNT_W | Task cycle budget N |
| tgt_freq | input | F_W | Target rate, in the units of the level table |
| ovh_en | input | 1 | Include the switch time in the split |
| ovh_cyc | input | OV_W | Switch time in cycles of the target rate |
| tick | input | 1 | One executed task cycle |
| speed_sel | output | LVL_W | Level index to apply to the next tick |
| busy | output | 1 | A run is being prepared or executed |
| done | output | 1 | One-cycle pulse at the end of a run |
| clamped | output | 1 | The target lay outside the table range |

## Verification
`busy` is due one edge after the accepted start. The bench checks it right after that edge. The split takes a fixed NUM_W+3 edges to prepare, so the bench holds back counted ticks until NUM_W+4 edges have passed. It drives a few stray ticks inside that window to show they are not counted. From then on, every tick is judged against the `speed_sel` value in place during the cycle in which the tick is sampled. `done` must appear in the half-cycle sample that directly follows the sample holding the last tick, with `busy` already low. A scoreboard entry pushed at start is popped there and compared.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PREP = 2'd1,
    S_DIV  = 2'd2,
    S_RUN  = 2'd3
  } vfs_state_t;
endpackage

// File: rtl/vfs_lvl_pick.sv
module vfs_lvl_pick #(
  parameter int F_W    = 8,
  parameter int N_LVL  = 16,
  parameter int F_BASE = 5,
  parameter int F_STEP = 5,
  parameter int LVL_W  = $clog2(N_LVL)
) (
  input  logic [F_W-1:0]   fv,
  output logic [LVL_W-1:0] lo_idx,
  output logic [LVL_W-1:0] hi_idx,
  output logic [F_W-1:0]   f_lo,
  output logic [F_W-1:0]   f_hi,
  output logic             single,
  output logic             clamp
);
  localparam int F_TOP = F_BASE + (N_LVL - 1) * F_STEP;

  always_comb begin
    lo_idx = '0;
    hi_idx = LVL_W'(N_LVL - 1);
    for (int i = 0; i < N_LVL; i++) begin
      if (F_BASE + i * F_STEP <= int'(fv)) lo_idx = LVL_W'(i);
    end
    for (int i = N_LVL - 1; i >= 0; i--) begin
      if (F_BASE + i * F_STEP >= int'(fv)) hi_idx = LVL_W'(i);
    end
    f_lo   = F_W'(F_BASE + int'(lo_idx) * F_STEP);
    f_hi   = F_W'(F_BASE + int'(hi_idx) * F_STEP);
    single = (lo_idx == hi_idx);
    clamp  = (int'(fv) < F_BASE) || (int'(fv) > F_TOP);
  end
endmodule

// File: rtl/vfs_ceil_div.sv
module vfs_ceil_div #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             valid,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int C_W = $clog2(NUM_W + 1);

  logic [C_W-1:0] cnt;
  logic [DEN_W:0] trial;
  logic           fits;

  always_comb begin
    trial = {rem, quo[NUM_W-1]};
    fits  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b0;
      quo   <= '0;
      rem   <= '0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        quo <= num;
        rem <= '0;
        cnt <= C_W'(NUM_W);
      end else if (cnt != '0) begin
        rem <= fits ? DEN_W'(trial - {1'b0, den}) : DEN_W'(trial);
        quo <= {quo[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == C_W'(1)) valid <= 1'b1;
      end
    end
  end

  // R3
  rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && den != '0) |-> (rem < den));
endmodule

// File: rtl/vfreq_split.sv
module vfreq_split #(
  parameter int CNT_W  = 16,
  parameter int F_W    = 8,
  parameter int OV_W   = 8,
  parameter int N_LVL  = 16,
  parameter int F_BASE = 5,
  parameter int F_STEP = 5,
  parameter int LVL_W  = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cyc_total,
  input  logic [F_W-1:0]   tgt_freq,
  input  logic             ovh_en,
  input  logic [OV_W-1:0]  ovh_cyc,
  input  logic             tick,
  output logic [LVL_W-1:0] speed_sel,
  output logic             busy,
  output logic             done,
  output logic             clamped
);
  import vfs_pkg::*;

  localparam int NUM_W = CNT_W + 2 * F_W + 1;
  localparam int DEN_W = 2 * F_W;

  vfs_state_t       st;
  logic [CNT_W-1:0] n_r, nh_r, cnt;
  logic [F_W-1:0]   fv_r, fh_r, fl_r;
  logic [OV_W-1:0]  ov_r;
  logic             oe_r, single_r;
  logic [LVL_W-1:0] hi_r, lo_r;

  logic [LVL_W-1:0] pk_lo, pk_hi;
  logic [F_W-1:0]   pk_flo, pk_fhi;
  logic             pk_single, pk_clamp;

  logic [NUM_W-1:0] num_w, quo;
  logic [DEN_W-1:0] den_w, rem;
  logic             div_valid;
  logic [NUM_W:0]   q_up;
  logic [CNT_W-1:0] cnt_n;

  vfs_lvl_pick #(
    .F_W(F_W), .N_LVL(N_LVL), .F_BASE(F_BASE), .F_STEP(F_STEP), .LVL_W(LVL_W)
  ) u_pick (
    .fv(tgt_freq), .lo_idx(pk_lo), .hi_idx(pk_hi),
    .f_lo(pk_flo), .f_hi(pk_fhi), .single(pk_single), .clamp(pk_clamp)
  );

  always_comb begin
    num_w = NUM_W'(n_r) * NUM_W'(fh_r) * NUM_W'(fv_r - fl_r);
    if (oe_r) num_w = num_w + NUM_W'(ov_r) * NUM_W'(fh_r) * NUM_W'(fl_r);
    den_w = DEN_W'(fv_r) * DEN_W'(F_STEP);
    q_up  = {1'b0, quo} + (NUM_W + 1)'(rem != '0);
    cnt_n = cnt + 1'b1;
  end

  vfs_ceil_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .go(st == S_PREP), .num(num_w), .den(den_w),
    .valid(div_valid), .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      n_r <= '0; nh_r <= '0; cnt <= '0;
      fv_r <= '0; fh_r <= '0; fl_r <= '0; ov_r <= '0;
      oe_r <= 1'b0; single_r <= 1'b0; hi_r <= '0; lo_r <= '0;
      speed_sel <= '0; busy <= 1'b0; done <= 1'b0; clamped <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n_r <= cyc_total; fv_r <= tgt_freq; oe_r <= ovh_en; ov_r <= ovh_cyc;
          hi_r <= pk_hi; lo_r <= pk_lo; fh_r <= pk_fhi; fl_r <= pk_flo;
          single_r <= pk_single; clamped <= pk_clamp;
          busy <= 1'b1;
          st <= S_PREP;
        end
        S_PREP: st <= S_DIV;
        S_DIV: if (div_valid) begin
          if (single_r || q_up > (NUM_W + 1)'(n_r)) nh_r <= n_r;
          else nh_r <= CNT_W'(q_up);
          speed_sel <= hi_r;
          cnt <= '0;
          if (n_r == '0) begin
            done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_RUN;
          end
        end
        S_RUN: if (tick) begin
          cnt <= cnt_n;
          if (cnt_n == nh_r) speed_sel <= lo_r;
          if (cnt_n == n_r) begin
            done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(n_r) && $stable(fv_r) && $stable(clamped)));
  // R2
  bound_pair_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (hi_r >= lo_r && (hi_r - lo_r) <= LVL_W'(1)));
  // R7
  high_then_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && $past(st) == S_RUN && speed_sel != $past(speed_sel))
      |-> (speed_sel == lo_r));
endmodule

// File: tb/tb_vfreq_split.sv
module tb_vfreq_split;
  localparam int NUM_W = 33;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [15:0] cyc_total = '0;
  logic [7:0] tgt_freq = '0;
  logic       ovh_en = 1'b0;
  logic [7:0] ovh_cyc = '0;
  logic       tick = 1'b0;
  logic [3:0] speed_sel;
  logic       busy, done, clamped;

  int total = 0;
  int bad = 0;

  typedef struct {
    int n; int nh; int hi; int lo; int cl; string tag;
  } exp_t;
  exp_t exp_q[$];

  bit run_win = 1'b0;
  int nt = 0;
  int order_err = 0;
  bit prev_tick = 1'b0;

  always #4 clk = ~clk;

  vfreq_split dut (
    .clk(clk), .rst(rst), .start(start), .cyc_total(cyc_total),
    .tgt_freq(tgt_freq), .ovh_en(ovh_en), .ovh_cyc(ovh_cyc), .tick(tick),
    .speed_sel(speed_sel), .busy(busy), .done(done), .clamped(clamped)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: judges every counted tick and pops the scoreboard on done
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(nt == e.n, {e.tag, " R8 ticks before done"}, nt, e.n);
          check(prev_tick, {e.tag, " R8 done one cycle after last tick"}, int'(prev_tick), 1);
          check(busy == 1'b0, {e.tag, " R8 busy low with done"}, int'(busy), 0);
          check(order_err == 0, {e.tag, " R1 R2 R7 speed per tick"}, order_err, 0);
          check(int'(clamped) == e.cl, {e.tag, " R6 clamp flag"}, int'(clamped), e.cl);
        end
        nt = 0;
        order_err = 0;
      end
      prev_tick = 1'b0;
      if (run_win && tick && exp_q.size() != 0) begin
        int want;
        want = (nt < exp_q[0].nh) ? exp_q[0].hi : exp_q[0].lo;
        if (int'(speed_sel) != want) begin
          order_err++;
          $display("  tick %0d speed=%0d want=%0d", nt, speed_sel, want);
        end
        nt++;
        prev_tick = 1'b1;
      end
    end
  end

  task automatic run_case(input int n, input int fv, input int oe, input int ov,
                          input int nh, input int hi, input int lo, input int cl,
                          input int gap, input bit stray, input bit bad_start,
                          input string tag);
    exp_q.push_back('{n, nh, hi, lo, cl, tag});
    @(posedge clk); #1;
    start = 1'b1; cyc_total = 16'(n); tgt_freq = 8'(fv);
    ovh_en = oe[0]; ovh_cyc = 8'(ov);
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy after start"}, int'(busy), 1);
    if (stray) begin
      tick = 1'b1;
      repeat (3) @(posedge clk);
      #1 tick = 1'b0;
    end
    repeat (NUM_W + 4) @(posedge clk);
    #1 run_win = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      if (bad_start && k == 2) begin
        start = 1'b1; tgt_freq = 8'd200; cyc_total = 16'd3;
      end
      @(posedge clk); #1;
      tick = 1'b0;
      start = 1'b0;
      repeat (gap) @(posedge clk);
      #1;
    end
    repeat (3) @(posedge clk);
    #1 run_win = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R10 busy at reset", int'(busy), 0);
    check(done == 1'b0, "R10 done at reset", int'(done), 0);
    check(clamped == 1'b0, "R10 clamped at reset", int'(clamped), 0);
    check(speed_sel == 4'd0, "R10 speed at reset", int'(speed_sel), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);

    // R3 split between two inner levels
    run_case(100, 12, 0, 0, 50, 2, 1, 0, 0, 1'b1, 1'b0, "R3 fv12");
    run_case(37, 23, 0, 0, 25, 4, 3, 0, 1, 1'b0, 1'b0, "R3 fv23 round up");
    run_case(9, 78, 0, 0, 6, 15, 14, 0, 0, 1'b0, 1'b0, "R3 fv78 top pair");
    // R5 exact table levels
    run_case(40, 30, 0, 0, 40, 5, 5, 0, 0, 1'b0, 1'b0, "R5 fv30");
    run_case(12, 5, 0, 0, 12, 0, 0, 0, 0, 1'b0, 1'b0, "R5 bottom level");
    run_case(8, 80, 0, 0, 8, 15, 15, 0, 2, 1'b0, 1'b0, "R5 top level");
    // R6 saturation
    run_case(20, 90, 0, 0, 20, 15, 15, 1, 0, 1'b0, 1'b0, "R6 above top");
    run_case(10, 3, 0, 0, 10, 0, 0, 1, 0, 1'b1, 1'b0, "R6 below bottom");
    // R4 switch overhead
    run_case(50, 12, 1, 4, 35, 2, 1, 0, 0, 1'b0, 1'b0, "R4 overhead on");
    run_case(50, 12, 0, 4, 25, 2, 1, 0, 0, 1'b0, 1'b0, "R4 overhead off");
    run_case(10, 12, 1, 20, 10, 2, 1, 0, 0, 1'b0, 1'b0, "R4 limited to N");
    // R9 start during a run is ignored
    run_case(37, 23, 0, 0, 25, 4, 3, 0, 1, 1'b1, 1'b1, "R9 start while busy");

    repeat (5) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8 every run finished", exp_q.size(), 0);
    check(busy == 1'b0, "R9 idle after runs", int'(busy), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule